// File: doc/BRIEF.md
# Fetch Target Buffer

The block is a small direct-mapped table that sits beside the instruction fetch stage. Each cycle the fetch address is presented on the lookup side, and within the same cycle the block answers with the address to fetch next. If the table holds a valid entry for that address, the answer is the stored target, so a taken branch costs no fetch bubble. If it does not, the answer is the sequential address: the fetch address plus four bytes.

The table keeps only branches that were taken. When a branch resolves later in the pipeline, its address, its outcome and its target arrive on the update side. A taken outcome writes or refreshes the entry. A not-taken outcome removes the entry, but only when that entry belongs to the same branch.

Each entry is selected by the address bits just above the two byte-alignment bits. The remaining upper bits form the tag that must match. The number of entries is a power-of-two parameter. An update is committed at the clock edge and is seen by lookups from the following cycle on. Reset empties the whole table.

Top module: `fetch_target_buf`

## Requirements
- R1: After reset every entry is empty, so every lookup misses and returns the fetch address plus 4.
- R2: On a miss, `lk_next_pc` equals `lk_pc + 4` modulo 2^PC_W, so 0xFFFF_FFFC gives 0x0000_0000.
- R3: After a taken update (`upd_en`=1, `upd_taken`=1), a lookup of the same address hits and returns `upd_target`.
- R4: The entry index is `pc[ALIGN+IDX_W-1:ALIGN]` (bits 5:2 at the defaults) and the tag is `pc[PC_W-1:ALIGN+IDX_W]`. Bits 1:0 take no part in the match. An address that shares an entry but has a different tag misses.
- R5: A taken update to an entry that holds another tag replaces that entry, and the old address then misses.
- R6: A not-taken update (`upd_taken`=0) whose tag matches the valid stored tag clears the entry, so the next lookup of that address misses.
- R7: A not-taken update whose tag differs from the stored tag leaves the entry and its target unchanged.
- R8: An update takes effect at the clock edge. A lookup in the same cycle still sees the earlier contents, and lookups from the next cycle on see the new contents.
- R9: A taken update to an address already present refreshes its target.
- R10: While `upd_en` is 0, the update inputs have no effect on the table.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; empties the table |
| lk_pc | input | PC_W | Fetch address being looked up |
| lk_hit | output | 1 | A valid entry with a matching tag exists |
| lk_next_pc | output | PC_W | Predicted next fetch address |
| upd_en | input | 1 | Resolved branch update is present this cycle |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | 1 = taken, 0 = not taken |
| upd_target | input | PC_W | Resolved target of the branch |

## Verification
The assertions check four things on every cycle:
- a taken update leaves its entry valid with the written tag;
- a matching not-taken update leaves the entry cleared;
- the valid bits do not change while no update is present;
- the table is empty when reset is released.

Some behaviour is only visible at the ports, and only the bench scenarios show it: the same-cycle-versus-next-cycle visibility of an update, aliasing between addresses that share an entry, the wrap of the sequential address, and the use of the stored target over the sequential one on a hit.

// File: rtl/ftb_pkg.sv
package ftb_pkg;
    // Size of one instruction in bytes; the sequential next address adds this.
    localparam int unsigned INSN_BYTES = 4;

    typedef enum logic {
        OUTCOME_NT = 1'b0,
        OUTCOME_T  = 1'b1
    } outcome_e;
endpackage

// File: rtl/ftb_addr_split.sv
module ftb_addr_split #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 4,
    parameter int ALIGN = 2
) (
    input  logic [PC_W-1:0]             pc,
    output logic [IDX_W-1:0]            idx,
    output logic [PC_W-IDX_W-ALIGN-1:0] tag
);
    assign idx = pc[ALIGN+IDX_W-1:ALIGN];
    assign tag = pc[PC_W-1:ALIGN+IDX_W];
endmodule

// File: rtl/ftb_store.sv
module ftb_store
    import ftb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int DEPTH = 16,
    parameter int TAG_W = 26,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic             wr_taken,
    input  logic [PC_W-1:0]  wr_target,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vld,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PC_W-1:0]  rd_tgt
);
    logic [DEPTH-1:0] vld;
    logic [TAG_W-1:0] tag_mem [DEPTH];
    logic [PC_W-1:0]  tgt_mem [DEPTH];
    outcome_e         oc;

    assign oc = outcome_e'(wr_taken);

    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
        logic             v_q;
        logic [TAG_W-1:0] t_q;
        logic [PC_W-1:0]  d_q;
        logic             sel;

        assign sel = wr_en && (wr_idx == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_q <= 1'b0;
            end else if (sel) begin
                if (oc == OUTCOME_T) begin
                    v_q <= 1'b1;
                end else if (t_q == wr_tag) begin
                    v_q <= 1'b0;
                end
            end
        end

        always_ff @(posedge clk) begin
            if (sel && oc == OUTCOME_T) begin
                t_q <= wr_tag;
                d_q <= wr_target;
            end
        end

        assign vld[e]     = v_q;
        assign tag_mem[e] = t_q;
        assign tgt_mem[e] = d_q;
    end

    assign rd_vld = vld[rd_idx];
    assign rd_tag = tag_mem[rd_idx];
    assign rd_tgt = tgt_mem[rd_idx];

    // R3
    alloc_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken) |=> (vld[$past(wr_idx)] && tag_mem[$past(wr_idx)] == $past(wr_tag)));

    // R6
    evict_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && vld[wr_idx] && tag_mem[wr_idx] == wr_tag) |=> !vld[$past(wr_idx)]);

    // R10
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(vld));

    // R1
    reset_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vld == '0));
endmodule

// File: rtl/ftb_pick.sv
module ftb_pick
    import ftb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int TAG_W = 26
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [TAG_W-1:0] pc_tag,
    input  logic             ent_vld,
    input  logic [TAG_W-1:0] ent_tag,
    input  logic [PC_W-1:0]  ent_tgt,
    output logic             hit,
    output logic [PC_W-1:0]  next_pc
);
    always_comb begin
        hit     = ent_vld && (ent_tag == pc_tag);
        next_pc = hit ? ent_tgt : (pc + PC_W'(INSN_BYTES));
    end
endmodule

// File: rtl/fetch_target_buf.sv
module fetch_target_buf
    import ftb_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int DEPTH = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_next_pc,
    input  logic            upd_en,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic [PC_W-1:0] upd_target
);
    localparam int ALIGN = $clog2(INSN_BYTES);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int TAG_W = PC_W - IDX_W - ALIGN;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    logic             e_vld;
    logic [TAG_W-1:0] e_tag;
    logic [PC_W-1:0]  e_tgt;

    ftb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_lk_split (
        .pc  (lk_pc),
        .idx (lk_idx),
        .tag (lk_tag)
    );

    ftb_addr_split #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) u_up_split (
        .pc  (upd_pc),
        .idx (up_idx),
        .tag (up_tag)
    );

    ftb_store #(.PC_W(PC_W), .DEPTH(DEPTH), .TAG_W(TAG_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (upd_en),
        .wr_idx    (up_idx),
        .wr_tag    (up_tag),
        .wr_taken  (upd_taken),
        .wr_target (upd_target),
        .rd_idx    (lk_idx),
        .rd_vld    (e_vld),
        .rd_tag    (e_tag),
        .rd_tgt    (e_tgt)
    );

    ftb_pick #(.PC_W(PC_W), .TAG_W(TAG_W)) u_pick (
        .pc      (lk_pc),
        .pc_tag  (lk_tag),
        .ent_vld (e_vld),
        .ent_tag (e_tag),
        .ent_tgt (e_tgt),
        .hit     (lk_hit),
        .next_pc (lk_next_pc)
    );
endmodule

// File: tb/sim_fetch_target_buf.sv
`timescale 1ns/1ps
module sim_fetch_target_buf;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit;
    logic [31:0] lk_next_pc;
    logic        upd_en = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic [31:0] upd_target = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fetch_target_buf u0 (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit),
        .lk_next_pc(lk_next_pc), .upd_en(upd_en), .upd_pc(upd_pc),
        .upd_taken(upd_taken), .upd_target(upd_target)
    );

    typedef struct packed {
        logic        upd;
        logic        tk;
        logic [31:0] upc;
        logic [31:0] utgt;
        logic [31:0] lpc;
        logic        ehit;
        logic [31:0] enext;
        logic [7:0]  req;
    } vec_t;

    // Index = pc[5:2], tag = pc[31:6]. A=0x1008 and B=0x2008 share index 2.
    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_1008, 1'b0, 32'h0000_100C, 8'd1},       // R1 empty
        '{1'b1, 1'b1, 32'h0000_1008, 32'h0000_4000, 32'h0000_1008, 1'b0, 32'h0000_100C, 8'd8}, // R8 same cycle
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_1008, 1'b1, 32'h0000_4000, 8'd3},       // R3 hit
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_100A, 1'b1, 32'h0000_4000, 8'd4},       // R4 low bits ignored
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_2008, 1'b0, 32'h0000_200C, 8'd4},       // R4 alias misses
        '{1'b1, 1'b1, 32'h0000_1008, 32'h0000_5000, 32'h0000_1010, 1'b0, 32'h0000_1014, 8'd2}, // R2 miss
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_1008, 1'b1, 32'h0000_5000, 8'd9},       // R9 refresh
        '{1'b1, 1'b0, 32'h0000_2008, 32'h0, 32'h0000_1008, 1'b1, 32'h0000_5000, 8'd7},  // R7
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_1008, 1'b1, 32'h0000_5000, 8'd7},       // R7 kept
        '{1'b1, 1'b1, 32'h0000_2008, 32'h0000_6000, 32'h0000_1008, 1'b1, 32'h0000_5000, 8'd8}, // R8
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_1008, 1'b0, 32'h0000_100C, 8'd5},       // R5 old gone
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_2008, 1'b1, 32'h0000_6000, 8'd5},       // R5 new
        '{1'b1, 1'b0, 32'h0000_2008, 32'h0, 32'h0000_2008, 1'b1, 32'h0000_6000, 8'd8},  // R8
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_2008, 1'b0, 32'h0000_200C, 8'd6},       // R6 cleared
        '{1'b1, 1'b1, 32'h0000_1010, 32'h0000_0000, 32'h0000_1010, 1'b0, 32'h0000_1014, 8'd8}, // R8
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_1010, 1'b1, 32'h0000_0000, 8'd3},       // R3
        '{1'b1, 1'b1, 32'h0000_003C, 32'h0000_0008, 32'hFFFF_FFFC, 1'b0, 32'h0000_0000, 8'd2}, // R2 wrap
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'h0000_003C, 1'b1, 32'h0000_0008, 8'd3},       // R3 top index
        '{1'b0, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFC, 1'b0, 32'h0000_0000, 8'd4}        // R4 tag differs
    };

    task automatic check(input string req, input logic eh, input logic [31:0] en);
        n_cmp++;
        if (lk_hit !== eh || lk_next_pc !== en) begin
            n_bad++;
            $display("FAIL %s: hit=%0b next=%08h expected hit=%0b next=%08h",
                     req, lk_hit, lk_next_pc, eh, en);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            upd_en     = VEC[i].upd;
            upd_taken  = VEC[i].tk;
            upd_pc     = VEC[i].upc;
            upd_target = VEC[i].utgt;
            lk_pc      = VEC[i].lpc;
            #1;
            check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].ehit, VEC[i].enext);
        end
        // R10: disabled update with taken fields set must not allocate
        @(negedge clk);
        upd_en = 1'b0; upd_taken = 1'b1; upd_pc = 32'h0000_1008; upd_target = 32'h0000_7000;
        lk_pc = 32'h0000_1008;
        @(negedge clk);
        #1;
        check("R10 disabled alloc", 1'b0, 32'h0000_100C);
        // R10: disabled not-taken must not evict
        upd_taken = 1'b0; upd_pc = 32'h0000_1010;
        @(negedge clk);
        lk_pc = 32'h0000_1010;
        #1;
        check("R10 disabled evict", 1'b1, 32'h0000_0000);
        // R1: reset in mid-run empties the table
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 after reset", 1'b0, 32'h0000_1014);
        lk_pc = 32'h0000_003C;
        #1;
        check("R1 after reset top", 1'b0, 32'h0000_0040);
        finish_run();
    end
endmodule